// File: doc/BRIEF.md
# Configuration register slave with chained read return

This block is one slave on a single-master configuration bus that sets up peripherals without using the main system buses. The master presents a 10-bit address, 32-bit write data and separate read and write strobes. The slave holds four 32-bit registers at a parameterised base address. It answers an access that falls in its window by writing or returning a register, and it raises an acknowledge.

Slaves are wired in a chain that acts as a distributed multiplexer for read data and acknowledge. Each slave receives the read data and acknowledge of the slave upstream of it. When it is not answering, it passes them downstream unchanged. When it answers, it puts its own values in their place.

The master and the slave may run on unrelated clocks, so the transfer is a four-phase handshake:
- The master raises a strobe.
- The slave synchronises the strobe and then raises acknowledge.
- The master drops the strobe.
- The slave drops acknowledge once it sees the strobe low.

Address and write data must stay stable from the rising strobe until acknowledge falls.

Top module: `cfg_reg_slave`

## Requirements
- R1: After reset, all four registers read 0, and `ack_o`/`rdata_o` equal `chain_ack_i`/`chain_rdata_i`.
- R2: An access is claimed only when `addr_i[9:2]` equals `BASE_ADDR[9:2]`. `addr_i[1:0]` selects register 0 to 3.
- R3: A write strobe to a claimed address stores `wdata_i` in the selected register and leaves the other three unchanged.
- R4: While the slave acknowledges a read, `rdata_o` carries the current content of the selected register.
- R5: With the strobe raised between two clock edges, `ack_o` is high after the third following rising edge. It stays high for as long as the strobe is held.
- R6: After the strobe falls between two edges, `ack_o` is low after the third following rising edge.
- R7: For an address outside the window, `ack_o` and `rdata_o` follow `chain_ack_i` and `chain_rdata_i` throughout the strobe, and no register changes.
- R8: Read and write strobes raised together are ignored: no acknowledge is raised and no register changes.
- R9: While the slave acknowledges a write, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Register address from the master |
| wdata_i | input | 32 | Write data from the master |
| rd_i | input | 1 | Read strobe (master clock domain) |
| wr_i | input | 1 | Write strobe (master clock domain) |
| chain_rdata_i | input | 32 | Read data from the upstream slave |
| chain_ack_i | input | 1 | Acknowledge from the upstream slave |
| rdata_o | output | 32 | Read data toward the master |
| ack_o | output | 1 | Acknowledge toward the master |

## Verification
The hardest case to reach is an illegal strobe pair. Both strobes have to pass the synchronisers in the same cycle, so the decode sees the combination rather than a lone strobe. The bench raises both strobes on the same falling edge and holds them for many cycles. It then releases them and reads every register back through the normal read path, which shows that nothing was written. Pass-through is checked by driving distinct chain values while strobing addresses that differ from the window in each single bit of `addr_i[9:2]`.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_hs_fsm.sv
module cfg_hs_fsm
  import cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_s_i,
  input  logic wr_s_i,
  input  logic sel_i,
  output logic fire_o,
  output logic own_ack_o
);
  hs_state_e state_q, state_d;

  // one legal strobe, in our window, while idle
  assign fire_o = (state_q == HS_IDLE) && sel_i && (rd_s_i ^ wr_s_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (fire_o) state_d = HS_ACK;
      HS_ACK:  if (!rd_s_i && !wr_s_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else state_q <= state_d;
  end

  assign own_ack_o = (state_q == HS_ACK);

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_ack_o && (rd_s_i || wr_s_i)) |=> own_ack_o); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_ack_o && !rd_s_i && !wr_s_i) |=> !own_ack_o); // R6
  AST_ACK_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_ack_o) |-> $past(sel_i && (rd_s_i != wr_s_i))); // R2
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int N_REGS = 4,
  parameter int DW     = 32,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [N_REGS-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else if (we_i && (idx_i == IDX_W'(i))) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q)); // R7
endmodule

// File: rtl/cfg_reg_slave.sv
module cfg_reg_slave #(
  parameter int          AW          = 10,
  parameter int          DW          = 32,
  parameter int          N_REGS      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [9:0]  BASE_ADDR   = 10'h040
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] chain_rdata_i,
  input  logic          chain_ack_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o
);
  localparam int IDX_W = $clog2(N_REGS);
  localparam logic [AW-1:0] BASE_W = AW'(BASE_ADDR);

  logic [1:0]    strb_s;
  logic          rd_s, wr_s, sel, fire, own_ack;
  logic [DW-1:0] reg_rdata, rdata_q;

  cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_i, rd_i}),
    .q_o   (strb_s)
  );
  assign rd_s = strb_s[0];
  assign wr_s = strb_s[1];

  assign sel = (addr_i[AW-1:IDX_W] == BASE_W[AW-1:IDX_W]);

  cfg_hs_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_s_i   (rd_s),
    .wr_s_i   (wr_s),
    .sel_i    (sel),
    .fire_o   (fire),
    .own_ack_o(own_ack)
  );

  cfg_regs #(.N_REGS(N_REGS), .DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fire && wr_s),
    .idx_i  (addr_i[IDX_W-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(reg_rdata)
  );

  // snapshot read data at the access; writes return zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (fire) rdata_q <= rd_s ? reg_rdata : '0;
  end

  assign ack_o   = own_ack ? 1'b1 : chain_ack_i;
  assign rdata_o = own_ack ? rdata_q : chain_rdata_i;

  AST_FIRE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !(rd_s && wr_s)); // R8
  AST_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && wr_s) |=> (rdata_o == '0)); // R9
endmodule

// File: tb/sim_cfg_reg_slave.sv
module sim_cfg_reg_slave;
  localparam logic [9:0] BASE = 10'h040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] c_rdata = '0;
  logic        c_ack = 1'b0;
  logic [31:0] rdata;
  logic        ack;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  cfg_reg_slave #(.BASE_ADDR(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .chain_rdata_i(c_rdata), .chain_ack_i(c_ack),
    .rdata_o(rdata), .ack_o(ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'h1357_9BDF * (i + 1)) ^ (32'h0F0F_0000 + 32'(k));
  endfunction

  // one handshake; returns rdata seen with ack
  task automatic xfer(input logic [9:0] a, input bit is_wr, input logic [31:0] d,
                      output logic [31:0] got, input string req);
    int cnt;
    @(negedge clk);
    addr = a; wdata = d;
    if (is_wr) wr = 1'b1; else rd = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ack && cnt < 10);
    check(cnt == 3, req, 32'(cnt), 32'd3);   // R5 latency
    got = rdata;
    @(negedge clk);
    check(ack == 1'b1, "R5", 32'(ack), 32'd1);   // held
    wr = 1'b0; rd = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (ack && cnt < 10);
    check(cnt == 3, "R6", 32'(cnt), 32'd3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] shadow [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and pass-through while idle
    c_rdata = 32'hCAFE_0001; c_ack = 1'b1;
    @(negedge clk);
    check(ack == 1'b1 && rdata == 32'hCAFE_0001, "R1", rdata, 32'hCAFE_0001);
    c_rdata = '0; c_ack = 1'b0;
    for (int i = 0; i < 4; i++) begin
      xfer(BASE + 10'(i), 1'b0, '0, got, "R1");
      check(got == 32'd0, "R1", got, 32'd0);
      shadow[i] = '0;
    end

    // R3 R4 R9 sweep: two passes of writes, full read-back after each
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 4; i++) begin
        xfer(BASE + 10'(i), 1'b1, pat(i, k), got, "R3");
        check(got == 32'd0, "R9", got, 32'd0);
        shadow[i] = pat(i, k);
        for (int j = 0; j < 4; j++) begin
          xfer(BASE + 10'(j), 1'b0, '0, got, "R4");
          check(got == shadow[j], "R3", got, shadow[j]);
        end
      end
    end

    // R2 R7: each single-bit miss in addr[9:2] passes chain through
    for (int b = 2; b < 10; b++) begin
      logic [9:0] miss;
      miss = BASE ^ (10'd1 << b);
      @(negedge clk);
      addr = miss; wdata = 32'hFFFF_FFFF; wr = 1'b1;
      c_rdata = 32'hBEEF_0000 + 32'(b);
      for (int t = 0; t < 6; t++) begin
        c_ack = t[0];
        @(negedge clk);
        check(ack == c_ack && rdata == c_rdata, "R7", rdata, c_rdata);
      end
      wr = 1'b0; c_ack = 1'b0;
      repeat (4) @(negedge clk);
      check(ack == 1'b0, "R2", 32'(ack), 32'd0);
    end
    c_rdata = '0;
    for (int j = 0; j < 4; j++) begin
      xfer(BASE + 10'(j), 1'b0, '0, got, "R7");
      check(got == shadow[j], "R7", got, shadow[j]);
    end

    // R8: both strobes together on every register
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      addr = BASE + 10'(i); wdata = 32'h0BAD_0BAD; rd = 1'b1; wr = 1'b1;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        check(ack == 1'b0, "R8", 32'(ack), 32'd0);
      end
      rd = 1'b0; wr = 1'b0;
      repeat (4) @(negedge clk);
    end
    for (int j = 0; j < 4; j++) begin
      xfer(BASE + 10'(j), 1'b0, '0, got, "R8");
      check(got == shadow[j], "R8", got, shadow[j]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule